// File: doc/BRIEF.md
# Queue Fill and Block-Copy Engine

This block writes bulk data into byte queues kept in a shared memory. Each queue has 256 one-byte slots. A queue's slots sit at consecutive addresses that start at the queue number times 256. A host programs the engine with short runs of single-byte register writes. The write that completes a run starts one of four jobs:

- clearing a whole queue to zero,
- filling a whole queue with a constant,
- filling a span of slots with a constant,
- copying consecutive source bytes into a span of slots.

The engine drives one single-port memory. It moves at most one byte for each memory access. A copy therefore spends one cycle reading and the next cycle writing for every byte. While a job runs the engine holds `busy` high and ignores every register write. When the job ends it pulses `done` for one cycle. The host keeps the memory's other users off the port while `busy` is high.

Top module: `queue_fill_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `mem_re` are all low.
- R2: Writing a queue number with `cmd_sel` = 0 sets all 256 slots of that queue to 0x00.
- R3: Writing a queue number with `cmd_sel` = 1 and then a value with `cmd_sel` = 2 sets all 256 slots of that queue to the value.
- R4: A value written with `cmd_sel` = 5 goes into the slots from the stored first slot (`cmd_sel` = 3) through the stored last slot (`cmd_sel` = 4), both inclusive, of the stored queue. All other slots keep their contents.
- R5: A copy takes its parameters in this order: first slot (`cmd_sel` = 3), last slot (`cmd_sel` = 4), source low byte (`cmd_sel` = 6), source high byte (`cmd_sel` = 7). The last write starts the copy. Slot first+i receives the byte at source address src+i, for every slot up to last. For example, source 0xF000..0xF00F into slots 32..47 makes exactly 16 memory writes.
- R6: Slot s of queue q is at memory address q*256 + s. Writes made outside the target span leave neighbouring queues and slots unchanged.
- R7: `mem_re` and `mem_we` are never high in the same cycle. During a copy every read is followed in the next cycle by a write, so a copy of N bytes keeps `busy` high for 2N cycles.
- R8: `busy` rises at the clock edge that captures the starting write. It falls at the edge that performs the last memory write, so a fill of N slots is busy for N cycles. `done` is high for exactly the one cycle after `busy` falls.
- R9: Register writes made while `busy` is high have no effect. They do not start a job and they do not change any stored parameter.
- R10: When the last slot is lower than the first slot, the job makes no memory write. `busy` stays low and `done` pulses in the cycle after the starting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_we | input | 1 | Register write strobe |
| cmd_sel | input | 3 | Register select (0 clear, 1 queue, 2 fill value, 3 first, 4 last, 5 span value, 6 source low, 7 source high) |
| cmd_data | input | 8 | Register write data |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when a job ends |
| mem_addr | output | QUEUE_W+8 | Memory address |
| mem_re | output | 1 | Memory read strobe; read data returns on the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, registered by the memory |

## Verification
The write that starts a job is captured at a clock edge, and `busy` reads high at the falling edge that follows. From there it stays high for N sampled cycles for a fill and 2N for a copy. `done` is due at the first falling edge where `busy` reads low. The bench drives and samples only at falling edges, and it counts the busy cycles from the falling edge after the starting write. Memory contents are checked only after `done`, because the last write lands at the same edge where `busy` falls.

// File: rtl/qfe_pkg.sv
package qfe_pkg;
    localparam int SLOT_W = 8;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CLEAR  = 3'd0,
        SEL_QUEUE  = 3'd1,
        SEL_FILL   = 3'd2,
        SEL_FIRST  = 3'd3,
        SEL_LAST   = 3'd4,
        SEL_RANGE  = 3'd5,
        SEL_SRC_LO = 3'd6,
        SEL_SRC_HI = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_WRITE
    } eng_state_e;
endpackage

// File: rtl/qfe_cmd_decode.sv
module qfe_cmd_decode
    import qfe_pkg::*;
#(
    parameter int QUEUE_W = 8,
    localparam int ADDR_W = QUEUE_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              busy,
    output logic              start,
    output logic              start_copy,
    output logic [QUEUE_W-1:0] job_queue,
    output logic [SLOT_W-1:0] job_first,
    output logic [SLOT_W-1:0] job_last,
    output logic [DATA_W-1:0] job_value,
    output logic [ADDR_W-1:0] job_src
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    typedef struct packed {
        logic [QUEUE_W-1:0] queue;
        logic [SLOT_W-1:0]  first;
        logic [SLOT_W-1:0]  last;
        logic [DATA_W-1:0]  src_lo;
    } param_t;

    param_t p_d, p_q;

    always_comb begin
        p_d        = p_q;
        start      = 1'b0;
        start_copy = 1'b0;
        job_queue  = p_q.queue;
        job_first  = p_q.first;
        job_last   = p_q.last;
        job_value  = cmd_data;
        job_src    = {cmd_data[QUEUE_W-1:0], p_q.src_lo};
        if (cmd_we && !busy) begin
            unique case (reg_sel_e'(cmd_sel))
                SEL_CLEAR: begin
                    start     = 1'b1;
                    job_queue = cmd_data[QUEUE_W-1:0];
                    job_first = '0;
                    job_last  = SLOT_MAX;
                    job_value = '0;
                end
                SEL_QUEUE:  p_d.queue  = cmd_data[QUEUE_W-1:0];
                SEL_FILL: begin
                    start     = 1'b1;
                    job_first = '0;
                    job_last  = SLOT_MAX;
                end
                SEL_FIRST:  p_d.first  = cmd_data;
                SEL_LAST:   p_d.last   = cmd_data;
                SEL_RANGE:  start      = 1'b1;
                SEL_SRC_LO: p_d.src_lo = cmd_data;
                SEL_SRC_HI: begin
                    start      = 1'b1;
                    start_copy = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end
endmodule

// File: rtl/qfe_seq.sv
module qfe_seq
    import qfe_pkg::*;
#(
    parameter int QUEUE_W = 8,
    localparam int ADDR_W = QUEUE_W + SLOT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               start_copy,
    input  logic [QUEUE_W-1:0] job_queue,
    input  logic [SLOT_W-1:0]  job_first,
    input  logic [SLOT_W-1:0]  job_last,
    input  logic [DATA_W-1:0]  job_value,
    input  logic [ADDR_W-1:0]  job_src,
    output eng_state_e         state,
    output logic [QUEUE_W-1:0] cur_queue,
    output logic [SLOT_W-1:0]  cur_slot,
    output logic [DATA_W-1:0]  cur_value,
    output logic [ADDR_W-1:0]  cur_src,
    output logic               busy,
    output logic               done
);
    localparam logic [SLOT_W-1:0] SLOT_ONE = 1;
    localparam logic [ADDR_W-1:0] SRC_ONE  = 1;

    typedef struct packed {
        eng_state_e         state;
        logic [QUEUE_W-1:0] queue;
        logic [SLOT_W-1:0]  slot;
        logic [SLOT_W-1:0]  last;
        logic [DATA_W-1:0]  value;
        logic [ADDR_W-1:0]  src;
        logic               done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.queue = job_queue;
                    s_d.slot  = job_first;
                    s_d.last  = job_last;
                    s_d.value = job_value;
                    s_d.src   = job_src;
                    if (job_last < job_first) s_d.done  = 1'b1;
                    else if (start_copy)      s_d.state = ST_READ;
                    else                      s_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                if (s_q.slot == s_q.last) begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.slot = s_q.slot + SLOT_ONE;
                end
            end
            ST_READ: s_d.state = ST_WRITE;
            ST_WRITE: begin
                s_d.src = s_q.src + SRC_ONE;
                if (s_q.slot == s_q.last) begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.slot  = s_q.slot + SLOT_ONE;
                    s_d.state = ST_READ;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign state     = s_q.state;
    assign cur_queue = s_q.queue;
    assign cur_slot  = s_q.slot;
    assign cur_value = s_q.value;
    assign cur_src   = s_q.src;
    assign busy      = (s_q.state != ST_IDLE);
    assign done      = s_q.done;
endmodule

// File: rtl/qfe_addr_gen.sv
module qfe_addr_gen
    import qfe_pkg::*;
#(
    parameter int QUEUE_W = 8,
    localparam int ADDR_W = QUEUE_W + SLOT_W
) (
    input  eng_state_e         state,
    input  logic [QUEUE_W-1:0] cur_queue,
    input  logic [SLOT_W-1:0]  cur_slot,
    input  logic [DATA_W-1:0]  cur_value,
    input  logic [ADDR_W-1:0]  cur_src,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata
);
    logic [ADDR_W-1:0] slot_addr;

    // queue base is queue * 256: the queue number forms the upper bits
    assign slot_addr = {cur_queue, cur_slot};

    always_comb begin
        mem_addr  = slot_addr;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = cur_value;
        unique case (state)
            ST_FILL:  mem_we = 1'b1;
            ST_READ: begin
                mem_addr = cur_src;
                mem_re   = 1'b1;
            end
            ST_WRITE: begin
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/queue_fill_engine.sv
module queue_fill_engine
    import qfe_pkg::*;
#(
    parameter int QUEUE_W = 8,
    localparam int ADDR_W = QUEUE_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic               start, start_copy;
    logic [QUEUE_W-1:0] job_queue, cur_queue;
    logic [SLOT_W-1:0]  job_first, job_last, cur_slot;
    logic [DATA_W-1:0]  job_value, cur_value;
    logic [ADDR_W-1:0]  job_src, cur_src;
    eng_state_e         state;

    qfe_cmd_decode #(.QUEUE_W(QUEUE_W)) u_dec (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .busy(busy), .start(start),
        .start_copy(start_copy), .job_queue(job_queue),
        .job_first(job_first), .job_last(job_last),
        .job_value(job_value), .job_src(job_src)
    );

    qfe_seq #(.QUEUE_W(QUEUE_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .start_copy(start_copy),
        .job_queue(job_queue), .job_first(job_first), .job_last(job_last),
        .job_value(job_value), .job_src(job_src), .state(state),
        .cur_queue(cur_queue), .cur_slot(cur_slot), .cur_value(cur_value),
        .cur_src(cur_src), .busy(busy), .done(done)
    );

    qfe_addr_gen #(.QUEUE_W(QUEUE_W)) u_agen (
        .state(state), .cur_queue(cur_queue), .cur_slot(cur_slot),
        .cur_value(cur_value), .cur_src(cur_src), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/qfe_checker.sv
module qfe_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_we,
    input logic              busy,
    input logic              done,
    input logic              mem_re,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

    assert_no_rw_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    assert_read_then_write_R7: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> mem_we);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_start_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_we));

    assert_fill_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_ONE));
endmodule

bind queue_fill_engine qfe_checker #(.ADDR_W(ADDR_W)) u_qfe_chk (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .busy(busy), .done(done),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tb_queue_fill_engine.sv
`timescale 1ns/1ps
module tb_queue_fill_engine;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_we;
    logic [2:0]  cmd_sel;
    logic [7:0]  cmd_data;
    logic        busy, done, mem_re, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    int checks = 0;
    int errors = 0;
    int wcnt   = 0;

    logic [7:0] mem [int];

    always #4 clk = ~clk;   // 125 MHz

    queue_fill_engine dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .busy(busy), .done(done), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] peek(int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // single-port memory model, registered read
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= peek(int'(mem_addr));
        if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            wcnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] sel, input logic [7:0] data);
        cmd_we = 1'b1; cmd_sel = sel; cmd_data = data;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic run_job(output int bcyc, output bit dn);
        bcyc = 0;
        while (busy) begin
            bcyc++;
            @(negedge clk);
        end
        dn = done;
    endtask

    task automatic check_span(input int q, input int lo, input int hi,
                              input logic [7:0] v, input string tag);
        int bad = -1;
        for (int s = lo; s <= hi; s++)
            if (bad < 0 && peek(q * 256 + s) != v) bad = s;
        chk(bad < 0, tag, (bad < 0) ? int'(v) : int'(peek(q * 256 + bad)), int'(v));
    endtask

    task automatic t_reset;
        chk(!busy && !done, "R1 busy/done after reset", int'({busy, done}), 0);
        chk(!mem_we && !mem_re, "R1 memory strobes after reset", int'({mem_we, mem_re}), 0);
    endtask

    task automatic t_clear;
        int b; bit d; int w0 = wcnt;
        reg_wr(3'd0, 8'd3);
        run_job(b, d);
        chk(b == 256, "R8 clear busy cycles", b, 256);
        chk(d, "R8 done after clear", int'(d), 1);
        @(negedge clk);
        check_span(3, 0, 255, 8'h00, "R2 queue 3 cleared");
        chk(peek(2 * 256 + 255) == 8'hA5 && peek(4 * 256) == 8'hA5,
            "R6 neighbours of queue 3 intact", int'(peek(4 * 256)), 'hA5);
        chk(wcnt - w0 == 256, "R2 clear write count", wcnt - w0, 256);
    endtask

    task automatic t_fill;
        int b; bit d; int w0 = wcnt;
        reg_wr(3'd1, 8'd7);
        reg_wr(3'd2, 8'h5C);
        run_job(b, d);
        @(negedge clk);
        check_span(7, 0, 255, 8'h5C, "R3 queue 7 filled");
        chk(wcnt - w0 == 256, "R3 fill write count", wcnt - w0, 256);
    endtask

    task automatic t_range;
        int b; bit d;
        reg_wr(3'd1, 8'd2);
        reg_wr(3'd3, 8'd0);
        reg_wr(3'd4, 8'd99);
        reg_wr(3'd5, 8'h9F);
        run_job(b, d);
        chk(b == 100, "R8 span busy cycles", b, 100);
        @(negedge clk);
        check_span(2, 0, 99, 8'h9F, "R4 span 0..99 of queue 2");
        check_span(2, 100, 255, 8'hA5, "R4 queue 2 beyond span untouched");
    endtask

    task automatic t_copy;
        int b; bit d; int w0 = wcnt;
        for (int i = 0; i < 16; i++) mem['hF000 + i] = 8'(i * 7 + 1);
        reg_wr(3'd1, 8'd3);
        reg_wr(3'd3, 8'd32);
        reg_wr(3'd4, 8'd47);
        reg_wr(3'd6, 8'h00);
        reg_wr(3'd7, 8'hF0);
        run_job(b, d);
        chk(b == 32, "R7 copy busy cycles", b, 32);
        chk(d, "R8 done after copy", int'(d), 1);
        @(negedge clk);
        chk(wcnt - w0 == 16, "R5 copy write count", wcnt - w0, 16);
        begin
            int bad = -1;
            for (int i = 0; i < 16; i++)
                if (bad < 0 && peek(3 * 256 + 32 + i) != 8'(i * 7 + 1)) bad = i;
            chk(bad < 0, "R5 copied bytes in slots 32..47", bad, -1);
        end
        chk(peek(3 * 256 + 31) == 8'h00 && peek(3 * 256 + 48) == 8'h00,
            "R5 slots 31 and 48 untouched", int'(peek(3 * 256 + 48)), 0);
    endtask

    task automatic t_empty;
        int b; bit d; int w0 = wcnt;
        reg_wr(3'd1, 8'd6);
        reg_wr(3'd3, 8'd10);
        reg_wr(3'd4, 8'd9);
        reg_wr(3'd5, 8'h77);
        run_job(b, d);
        chk(b == 0, "R10 empty span busy cycles", b, 0);
        chk(d, "R10 done pulse on empty span", int'(d), 1);
        @(negedge clk);
        chk(wcnt - w0 == 0, "R10 empty span writes", wcnt - w0, 0);
    endtask

    task automatic t_busy_ignore;
        int b; bit d;
        reg_wr(3'd1, 8'd4);
        reg_wr(3'd2, 8'h11);
        reg_wr(3'd1, 8'd6);    // ignored: busy
        reg_wr(3'd2, 8'h22);   // ignored: busy
        run_job(b, d);
        chk(b + 2 == 256, "R9 busy length not restarted", b + 2, 256);
        repeat (3) @(negedge clk);
        chk(!busy, "R9 no job started by ignored write", int'(busy), 0);
        check_span(4, 0, 255, 8'h11, "R9 queue 4 holds first fill");
        check_span(6, 0, 255, 8'hA5, "R9 queue 6 untouched");
        reg_wr(3'd3, 8'd0);
        reg_wr(3'd4, 8'd0);
        reg_wr(3'd5, 8'h33);
        run_job(b, d);
        @(negedge clk);
        chk(peek(4 * 256) == 8'h33 && peek(6 * 256) == 8'hA5,
            "R9 stored queue kept after ignored write", int'(peek(4 * 256)), 'h33);
    endtask

    task automatic t_copy_edge;
        int b; bit d;
        mem['h1234] = 8'hC3;
        reg_wr(3'd1, 8'd1);
        reg_wr(3'd3, 8'd255);
        reg_wr(3'd4, 8'd255);
        reg_wr(3'd6, 8'h34);
        reg_wr(3'd7, 8'h12);
        run_job(b, d);
        chk(b == 2, "R7 single-byte copy busy cycles", b, 2);
        @(negedge clk);
        chk(peek(16'h01FF) == 8'hC3, "R6 slot 255 of queue 1 at 0x01FF",
            int'(peek(16'h01FF)), 'hC3);
        chk(peek(16'h0200) == 8'h9F, "R6 queue 2 slot 0 untouched",
            int'(peek(16'h0200)), 'h9F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_we = 1'b0; cmd_sel = '0; cmd_data = '0;
        foreach (mem[k]) mem.delete(k);
        for (int q = 1; q <= 6; q++)
            for (int s = 0; s < 256; s++) mem[q * 256 + s] = 8'hA5;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clear();
        t_fill();
        t_range();
        t_copy();
        t_empty();
        t_busy_ignore();
        t_copy_edge();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule